// File: doc/BRIEF.md
# Display Register SPI Transaction Engine

This block is a serial-peripheral master that performs register-level accesses on a small display controller. A local requester presents one of four commands (set index, write register, read register, read status) together with an 8-bit register index and a 16-bit write value. The engine turns the command into one or two chip-select frames on the serial lines, captures the bytes returned on the data-in line, and finishes with a single-cycle done pulse. Read commands also return a 16-bit result.

Every frame opens with a header byte that carries a one-bit device identifier, a register-select bit and a direction bit. Register writes and reads always take two frames: an index frame, then a value frame. Chip select goes high between the two frames. A status read is one longer frame in which the byte that arrives right after the header is thrown away. A static option complements every transmitted byte. The serial clock comes from the system clock through a divider set by the parameter `HALF_DIV`. It must give at most 4 MHz for register traffic, so the default is 32 system clocks per half period, which suits a 250 MHz system clock.

The controller is a six-state machine. States: `ST_IDLE` (chip select high, waiting), `ST_LOW` (clock low, data set up), `ST_HIGH` (clock high), `ST_TRAIL` (hold after the last falling edge), `ST_GAP` (chip select high between frames) and `ST_FINISH` (done pulse). Transitions:
- IDLE→LOW when a request is accepted.
- LOW→HIGH on a divider tick, sampling the data-in line.
- HIGH→LOW on a tick while bits remain, shifting the next bit out.
- HIGH→TRAIL on the tick after the last bit.
- TRAIL→GAP on a tick.
- GAP→LOW after two ticks when a value frame is still owed.
- GAP→FINISH after two ticks otherwise.
- FINISH→IDLE unconditionally.

Top module: `dspi_reg_engine`

## Requirements
- R1: Every frame begins with a header byte equal to 0x70 | (device_id<<2) | (rs<<1) | rw, where rs=0 selects the index register, rs=1 selects register data, rw=0 writes and rw=1 reads. Bytes are sent MSB first in SPI mode 0: the clock idles low, data-out changes only on falling clock edges, and both sides sample on rising edges.
- R2: Command code 0 (set index) sends one 3-byte frame: header(rs=0,rw=0), 0x00, then the register index.
- R3: Command code 1 (write) sends the set-index frame and then a separate 3-byte frame: header(rs=1,rw=0), value[15:8], value[7:0].
- R4: Command code 2 (read) sends the set-index frame and then a separate 3-byte frame: header(rs=1,rw=1), 0x00, 0x00. The result is the second received byte of that frame in bits 15:8 and the third in bits 7:0.
- R5: Command code 3 (status) sends one 4-byte frame: header(rs=0,rw=1) and three 0x00 bytes. The second received byte is discarded, and the result is the third received byte in bits 15:8 and the fourth in bits 7:0.
- R6: When the invert option is 1, every transmitted byte is bitwise complemented, including header and dummy bytes. Received bytes are not complemented.
- R7: The serial clock high and low phases each last exactly HALF_DIV system clocks. Chip select falls HALF_DIV clocks before the first rising edge and rises HALF_DIV clocks after the last falling edge.
- R8: Chip select stays high for at least 2*HALF_DIV clocks between frames, and the serial clock is low whenever chip select is high.
- R9: Busy rises the cycle after a request is accepted in idle and stays high until the cycle after done. Done is a one-cycle pulse issued while busy is high. A request made while busy is ignored and starts no frame.
- R10: The result output changes only in the cycle after done of a read or status command. Set-index and write commands leave it unchanged.
- R11: After reset, chip select is high, the serial clock is low, busy and done are low and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_dev_id_i | input | 1 | Static device identifier bit placed in every header |
| cfg_invert_i | input | 1 | Static option: complement transmitted bytes |
| req_valid_i | input | 1 | Request strobe, taken only when not busy |
| req_cmd_i | input | 2 | Command: 0 set index, 1 write, 2 read, 3 status |
| req_index_i | input | 8 | Register index |
| req_wdata_i | input | 16 | Value for a write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Result of the last read or status command |
| spi_clk_o | output | 1 | Serial clock, idle low |
| spi_csn_o | output | 1 | Active-low chip select |
| spi_dout_o | output | 1 | Serial data to the display controller |
| spi_din_i | input | 1 | Serial data from the display controller |

## Verification
The assertions assume three things about the inputs:
- The device-identifier and invert inputs stay constant while a transaction is in flight.
- Data-in changes only after a falling serial-clock edge, so it is stable when it is sampled on the rising edge.
- A request may be raised at any time, including while busy.

The stimulus changes configuration only while the block is idle. A behavioural slave in the bench changes data-in on the cycle it sees the clock fall. One transaction deliberately raises a second request mid-flight, to show that it is dropped.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned FRAME_BYTES = 4;
    localparam int unsigned FRAME_BITS  = BYTE_W * FRAME_BYTES;
    localparam int unsigned BITCNT_W    = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        CMD_SET_INDEX   = 2'd0,
        CMD_WRITE_REG   = 2'd1,
        CMD_READ_REG    = 2'd2,
        CMD_READ_STATUS = 2'd3
    } dspi_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL,
        ST_GAP,
        ST_FINISH
    } dspi_state_e;

    // Header: fixed 01110 prefix, then device id, register select, direction.
    function automatic logic [BYTE_W-1:0] head_byte(input logic dev_id,
                                                    input logic rs,
                                                    input logic rw);
        return {5'b01110, dev_id, rs, rw};
    endfunction
endpackage

// File: rtl/dspi_clk_div.sv
module dspi_clk_div #(
    parameter int unsigned HALF_DIV = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (!en_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dspi_frame_builder.sv
module dspi_frame_builder
    import dspi_pkg::*;
(
    input  dspi_cmd_e               cmd_i,
    input  logic                    second_i,
    input  logic [BYTE_W-1:0]       index_i,
    input  logic [2*BYTE_W-1:0]     wdata_i,
    input  logic                    dev_id_i,
    input  logic                    invert_i,
    output logic [FRAME_BITS-1:0]   frame_o,
    output logic [BITCNT_W-1:0]     nbits_o,
    output logic                    two_frame_o
);
    logic [BYTE_W-1:0] raw [FRAME_BYTES];

    always_comb begin
        for (int b = 0; b < FRAME_BYTES; b++) raw[b] = '0;
        nbits_o = BITCNT_W'(3 * BYTE_W);
        if (!second_i) begin
            if (cmd_i == CMD_READ_STATUS) begin
                raw[0]  = head_byte(dev_id_i, 1'b0, 1'b1);
                nbits_o = BITCNT_W'(FRAME_BITS);
            end else begin
                raw[0] = head_byte(dev_id_i, 1'b0, 1'b0);
                raw[2] = index_i;
            end
        end else if (cmd_i == CMD_WRITE_REG) begin
            raw[0] = head_byte(dev_id_i, 1'b1, 1'b0);
            raw[1] = wdata_i[2*BYTE_W-1:BYTE_W];
            raw[2] = wdata_i[BYTE_W-1:0];
        end else begin
            raw[0] = head_byte(dev_id_i, 1'b1, 1'b1);
        end
    end

    assign two_frame_o = (cmd_i == CMD_WRITE_REG) || (cmd_i == CMD_READ_REG);

    for (genvar b = 0; b < FRAME_BYTES; b++) begin : g_byte
        assign frame_o[(FRAME_BYTES-1-b)*BYTE_W +: BYTE_W] = raw[b] ^ {BYTE_W{invert_i}};
    end
endmodule

// File: rtl/dspi_shifter.sv
module dspi_shifter #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] frame_i,
    input  logic         shift_i,
    input  logic         sample_i,
    input  logic         din_i,
    output logic         dout_o,
    output logic [W-1:0] rx_o
);
    logic [W-1:0] tx_q, rx_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load_i) begin
            tx_q <= frame_i;
            rx_q <= '0;
        end else begin
            if (shift_i)  tx_q <= {tx_q[W-2:0], 1'b0};
            if (sample_i) rx_q <= {rx_q[W-2:0], din_i};
        end
    end

    assign dout_o = tx_q[W-1];
    assign rx_o   = rx_q;
endmodule

// File: rtl/dspi_reg_engine.sv
module dspi_reg_engine
    import dspi_pkg::*;
#(
    parameter int unsigned HALF_DIV = 32
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cfg_dev_id_i,
    input  logic        cfg_invert_i,
    input  logic        req_valid_i,
    input  logic [1:0]  req_cmd_i,
    input  logic [7:0]  req_index_i,
    input  logic [15:0] req_wdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        spi_clk_o,
    output logic        spi_csn_o,
    output logic        spi_dout_o,
    input  logic        spi_din_i
);
    dspi_state_e           state_q, state_d;
    dspi_cmd_e             cmd_q, cmd_sel;
    logic [BYTE_W-1:0]     idx_q, idx_sel;
    logic [2*BYTE_W-1:0]   wdata_q, wdata_sel;
    logic                  frame_sel_q, gap_half_q;
    logic [BITCNT_W-1:0]   bits_left_q, nbits;
    logic [FRAME_BITS-1:0] frame_word, rx_word;
    logic [15:0]           rdata_q;
    logic                  tick, div_en, two_frame;
    logic                  load_frame, sample_bit, shift_bit;

    assign div_en = (state_q != ST_IDLE) && (state_q != ST_FINISH);

    dspi_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(div_en), .tick_o(tick)
    );

    assign cmd_sel   = (state_q == ST_IDLE) ? dspi_cmd_e'(req_cmd_i) : cmd_q;
    assign idx_sel   = (state_q == ST_IDLE) ? req_index_i : idx_q;
    assign wdata_sel = (state_q == ST_IDLE) ? req_wdata_i : wdata_q;

    dspi_frame_builder u_build (
        .cmd_i(cmd_sel), .second_i(state_q == ST_GAP), .index_i(idx_sel),
        .wdata_i(wdata_sel), .dev_id_i(cfg_dev_id_i), .invert_i(cfg_invert_i),
        .frame_o(frame_word), .nbits_o(nbits), .two_frame_o(two_frame)
    );

    dspi_shifter #(.W(FRAME_BITS)) u_shift (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_frame), .frame_i(frame_word),
        .shift_i(shift_bit), .sample_i(sample_bit), .din_i(spi_din_i),
        .dout_o(spi_dout_o), .rx_o(rx_word)
    );

    // Next state and shifter control.
    always_comb begin
        state_d    = state_q;
        load_frame = 1'b0;
        sample_bit = 1'b0;
        shift_bit  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid_i) begin
                load_frame = 1'b1;
                state_d    = ST_LOW;
            end
            ST_LOW: if (tick) begin
                sample_bit = 1'b1;
                state_d    = ST_HIGH;
            end
            ST_HIGH: if (tick) begin
                shift_bit = 1'b1;
                state_d   = (bits_left_q == BITCNT_W'(1)) ? ST_TRAIL : ST_LOW;
            end
            ST_TRAIL: if (tick) state_d = ST_GAP;
            ST_GAP: if (tick && gap_half_q) begin
                if (two_frame && !frame_sel_q) begin
                    load_frame = 1'b1;
                    state_d    = ST_LOW;
                end else begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Transaction context.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmd_q       <= CMD_SET_INDEX;
            idx_q       <= '0;
            wdata_q     <= '0;
            frame_sel_q <= 1'b0;
            gap_half_q  <= 1'b0;
            bits_left_q <= '0;
            rdata_q     <= '0;
        end else begin
            if (load_frame && state_q == ST_IDLE) begin
                cmd_q       <= cmd_sel;
                idx_q       <= req_index_i;
                wdata_q     <= req_wdata_i;
                frame_sel_q <= 1'b0;
            end else if (load_frame) begin
                frame_sel_q <= 1'b1;
            end
            if (load_frame)     bits_left_q <= nbits;
            else if (shift_bit) bits_left_q <= bits_left_q - 1'b1;
            if (state_q != ST_GAP) gap_half_q <= 1'b0;
            else if (tick)         gap_half_q <= 1'b1;
            if (state_q == ST_FINISH &&
                (cmd_q == CMD_READ_REG || cmd_q == CMD_READ_STATUS))
                rdata_q <= rx_word[15:0];
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_FINISH);
        spi_clk_o = (state_q == ST_HIGH);
        spi_csn_o = (state_q == ST_IDLE) || (state_q == ST_GAP) || (state_q == ST_FINISH);
        rdata_o   = rdata_q;
    end

    // R1
    dout_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!spi_csn_o && $past(!spi_csn_o) && !$fell(spi_clk_o)) |-> $stable(spi_dout_o));
    // R8
    clk_low_after_csn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spi_csn_o |=> !spi_clk_o);
    // R9
    busy_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !busy_o) |=> busy_o);
    // R9
    done_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (busy_o ##1 (!busy_o && !done_o)));
    // R10
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |=> $stable(rdata_o));
endmodule

// File: tb/dspi_reg_engine_tb.sv
module dspi_reg_engine_tb_top;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_id = 1'b1, cfg_inv = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = 2'd0;
    logic [7:0]  req_index = 8'h00;
    logic [15:0] req_wdata = 16'h0000;
    logic        busy, done, sclk, csn, mosi;
    logic        miso = 1'b0;
    logic [15:0] rdata;

    int checks = 0, errors = 0, frames_seen = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dspi_reg_engine #(.HALF_DIV(H)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_dev_id_i(cfg_id), .cfg_invert_i(cfg_inv),
        .req_valid_i(req_valid), .req_cmd_i(req_cmd), .req_index_i(req_index),
        .req_wdata_i(req_wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .spi_clk_o(sclk), .spi_csn_o(csn), .spi_dout_o(mosi), .spi_din_i(miso)
    );

    typedef struct { logic [31:0] word; int nbits; string tag; } frame_t;
    frame_t      exp_q[$];
    logic [31:0] reply_q[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] hdr(input logic id, input logic rs, input logic rw);
        return 8'h70 | (8'(id) << 2) | (8'(rs) << 1) | 8'(rw);
    endfunction

    function automatic logic [7:0] tx(input logic [7:0] b);
        return cfg_inv ? ~b : b;
    endfunction

    // Behavioural slave and line monitor, evaluated every clock.
    logic        prev_csn = 1'b1, prev_sclk = 1'b0;
    int          run = 1, nb = 0, rbit = 0;
    logic [31:0] cap = 0, cur_reply = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_csn = 1'b1; prev_sclk = 1'b0; run = 1;
        end else begin
            check(!(csn && sclk), "R8 clock high with chip select high", 32'(sclk), 32'd0);
            if (prev_csn && !csn) begin
                if (frames_seen > 0)
                    check(run >= 2*H, "R8 chip-select gap", run, 2*H);
                cap = 0; nb = 0;
                cur_reply = (reply_q.size() > 0) ? reply_q.pop_front() : 32'h0;
                miso = cur_reply[31]; rbit = 1;
            end
            if (!prev_sclk && sclk) begin
                check(run == H, "R7 low phase / lead", run, H);
                cap = {cap[30:0], mosi}; nb++;
            end
            if (prev_sclk && !sclk) begin
                check(run == H, "R7 high phase", run, H);
                if (rbit < 32) miso = cur_reply[31-rbit];
                rbit++;
            end
            if (!prev_csn && csn) begin
                check(run == H, "R7 trail", run, H);
                frames_seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected frame", cap, 32'h0);
                end else begin
                    frame_t e;
                    e = exp_q.pop_front();
                    check(nb == e.nbits, {e.tag, " frame length"}, nb, e.nbits);
                    check(cap == ((e.nbits == 32) ? e.word : {8'h00, e.word[31:8]}),
                          {e.tag, " frame bytes"}, cap,
                          (e.nbits == 32) ? e.word : {8'h00, e.word[31:8]});
                end
            end
            run = ((csn != prev_csn) || (sclk != prev_sclk)) ? 1 : run + 1;
            prev_csn = csn; prev_sclk = sclk;
        end
    end

    logic [15:0] exp_rdata = 16'h0000;

    task automatic run_cmd(input logic [1:0] cmd, input logic [7:0] idx, input logic [15:0] wd,
                           input logic [31:0] rep0, input logic [31:0] rep1, input bit extra);
        frame_t f;
        int n, seen0;
        string t;
        t = (cmd == 2'd0) ? "R1 R2" : (cmd == 2'd1) ? "R1 R3" : (cmd == 2'd2) ? "R1 R4" : "R1 R5";
        if (cfg_inv) t = {t, " R6"};
        if (cmd == 2'd3) begin
            f.word = {tx(hdr(cfg_id, 1'b0, 1'b1)), tx(8'h00), tx(8'h00), tx(8'h00)};
            f.nbits = 32; f.tag = t; exp_q.push_back(f); reply_q.push_back(rep0);
            exp_rdata = rep0[15:0];
        end else begin
            f.word = {tx(hdr(cfg_id, 1'b0, 1'b0)), tx(8'h00), tx(idx), 8'h00};
            f.nbits = 24; f.tag = t; exp_q.push_back(f); reply_q.push_back(rep0);
            if (cmd == 2'd1) begin
                f.word = {tx(hdr(cfg_id, 1'b1, 1'b0)), tx(wd[15:8]), tx(wd[7:0]), 8'h00};
                exp_q.push_back(f); reply_q.push_back(rep1);
            end else if (cmd == 2'd2) begin
                f.word = {tx(hdr(cfg_id, 1'b1, 1'b1)), tx(8'h00), tx(8'h00), 8'h00};
                exp_q.push_back(f); reply_q.push_back(rep1);
                exp_rdata = rep1[23:8];
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_index = idx; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
        if (extra) begin
            repeat (10) @(negedge clk);
            req_valid = 1'b1; req_cmd = 2'd3; req_index = 8'h5A;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        check(done == 1'b1, "R9 done reached", 32'(done), 32'd1);
        check(busy == 1'b1, "R9 busy during done", 32'(busy), 32'd1);
        @(negedge clk);
        check(!done && !busy, "R9 done single pulse then idle", {30'd0, done, busy}, 32'd0);
        check(rdata == exp_rdata, {t, " R10 result"}, 32'(rdata), 32'(exp_rdata));
        check(exp_q.size() == 0, {t, " frame count"}, exp_q.size(), 0);
        if (extra) begin
            seen0 = frames_seen;
            repeat (100) @(negedge clk);
            check(frames_seen == seen0 && csn && !busy, "R9 request while busy ignored",
                  frames_seen, seen0);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(csn && !sclk && !busy && !done && rdata == 16'h0, "R11 reset state",
              {csn, sclk, busy, done, 12'h0, rdata}, {1'b1, 3'b000, 12'h0, 16'h0});
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_cmd(2'd0, 8'h21, 16'h0000, 32'hFFFF_FFFF, 32'h0, 0);
        run_cmd(2'd1, 8'h10, 16'h4240, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 0);
        run_cmd(2'd2, 8'h00, 16'h0000, 32'h1111_1111, 32'hC3_9222_00, 0);
        run_cmd(2'd3, 8'h00, 16'h0000, 32'h00_EE_1234, 32'h0, 0);
        run_cmd(2'd1, 8'h3C, 16'hBEEF, 32'h0, 32'h0, 0);
        cfg_id = 1'b0; cfg_inv = 1'b1;
        run_cmd(2'd1, 8'h56, 16'h080F, 32'h0, 32'h0, 0);
        run_cmd(2'd2, 8'h44, 16'h0000, 32'h0, 32'h7E_AF00_81, 0);
        run_cmd(2'd3, 8'h00, 16'h0000, 32'h80_01_C0DE, 32'h0, 0);
        cfg_id = 1'b1; cfg_inv = 1'b0;
        run_cmd(2'd1, 8'h07, 16'h0037, 32'h0, 32'h0, 1);
        repeat (10) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule